// File: doc/BRIEF.md
# PWM-Locked ADC Trigger Generator

This block issues ADC start-of-conversion strobes at fixed points within a motor-control PWM carrier period. An external up/down carrier counter provides its present count and counting direction. The block holds a small set of trigger channels. Each channel has a compare value, a slope selection and an output route. A channel fires a one-clock strobe on its routed output line when the carrier count equals its compare value on a slope that the channel accepts.

Software writes land in shadow registers only. Every channel copies its shadow compare value, slope and route into its active registers on the PWM period sync strobe, so a carrier period never runs with a half-applied setting. When the carrier is in edge-aligned mode, matches count only while the counter is rising. When the PWM output is switched off, every trigger line stays low.

Top module: `adc_sync_trig`

## Requirements
- R1: When the count input equals a channel's active compare value on a slope the channel accepts, with the enable high at a rising clock edge, the channel's routed output bit goes high for the next clock period.
- R2: The 2-bit slope code per channel is 00 = never fire, 01 = fire on up-count match (direction input 1), 10 = fire on down-count match (direction input 0), 11 = fire on either direction.
- R3: While edge-aligned mode is high, a channel whose slope code is not 00 fires only on up-count matches, whatever its slope code.
- R4: A clock edge that samples the PWM-enable input low yields all trigger outputs low in the following period.
- R5: Compare writes and slope/route writes go to shadow registers. A channel's active compare, slope and route take the shadow values only at a clock edge where the sync strobe is high, and keep them until the next such edge.
- R6: A channel fires once per entry into a match. If the qualifying match holds over consecutive edges, no further pulse follows the first.
- R7: Each channel's 2-bit route field selects output bit 0..3. Channels routed to the same output are OR-combined.
- R8: After reset, every active and shadow compare is 0, every slope is 00, every route is 0, and all outputs are low. A count of 0 therefore produces no trigger.
- R9: The two channels compare and fire independently of each other. Channel c uses bits [2c+1:2c] of the slope and route write buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Carrier count value |
| cnt_up_i | input | 1 | Carrier direction, 1 = counting up |
| pwm_en_i | input | 1 | PWM output enable; low silences all triggers |
| edge_mode_i | input | 1 | Edge-aligned carrier mode, forces up-slope matching |
| pwm_sync_i | input | 1 | Period boundary strobe that commits shadow settings |
| cmp_we_i | input | 2 | Per-channel compare shadow write enable |
| cmp_wdata_i | input | 16 | Compare write data |
| cfg_we_i | input | 1 | Slope and route shadow write enable, all channels |
| cfg_slope_i | input | 4 | Slope codes, channel c at [2c+1:2c] |
| cfg_route_i | input | 4 | Output routes, channel c at [2c+1:2c] |
| trig_o | output | 4 | Trigger pulse lines |

## Verification
Each trigger is due exactly one clock after the edge that samples the matching count. Only the output register lies between the comparison and the pin. A shadow write takes effect only at the edge that samples sync high, so the first match that can use it is the edge after that. The bench drives every input on the falling edge and waits for the next rising edge. It then samples the outputs 1 ns later, so each check reads the period that follows the edge holding the stimulus. Held-match and write-without-sync cases are checked across several such periods, each checked on its own.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    SLOPE_OFF  = 2'b00,
    SLOPE_UP   = 2'b01,
    SLOPE_DN   = 2'b10,
    SLOPE_BOTH = 2'b11
  } slope_e;

  // Decide whether the present direction is an accepted match slope.
  function automatic logic slope_allows(slope_e s, logic up, logic edge_m);
    logic [1:0] sb;
    sb = s;
    if (edge_m) slope_allows = (sb != 2'b00) && up;
    else        slope_allows = up ? sb[0] : sb[1];
  endfunction

endpackage

// File: rtl/adc_trig_chan.sv
module adc_trig_chan
  import adc_trig_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ROUTE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               cnt_up_i,
  input  logic               edge_mode_i,
  input  logic               pwm_en_i,
  input  logic               sync_i,
  input  logic               cmp_we_i,
  input  logic [CNT_W-1:0]   cmp_wdata_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         slope_wdata_i,
  input  logic [ROUTE_W-1:0] route_wdata_i,
  output logic               hit_o,
  output logic [ROUTE_W-1:0] route_o,
  output logic [CNT_W-1:0]   act_cmp_o
);

  logic [CNT_W-1:0]   sh_cmp_q, sh_cmp_d, act_cmp_q, act_cmp_d;
  slope_e             sh_slope_q, sh_slope_d, act_slope_q, act_slope_d;
  logic [ROUTE_W-1:0] sh_route_q, sh_route_d, act_route_q, act_route_d;
  logic               prev_q, qual;

  always_comb begin
    sh_cmp_d    = sh_cmp_q;
    sh_slope_d  = sh_slope_q;
    sh_route_d  = sh_route_q;
    act_cmp_d   = act_cmp_q;
    act_slope_d = act_slope_q;
    act_route_d = act_route_q;
    if (cmp_we_i) sh_cmp_d = cmp_wdata_i;
    if (cfg_we_i) begin
      sh_slope_d = slope_e'(slope_wdata_i);
      sh_route_d = route_wdata_i;
    end
    if (sync_i) begin
      act_cmp_d   = sh_cmp_q;
      act_slope_d = sh_slope_q;
      act_route_d = sh_route_q;
    end
    qual = pwm_en_i && (cnt_i == act_cmp_q)
           && slope_allows(act_slope_q, cnt_up_i, edge_mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_cmp_q    <= '0;
      sh_slope_q  <= SLOPE_OFF;
      sh_route_q  <= '0;
      act_cmp_q   <= '0;
      act_slope_q <= SLOPE_OFF;
      act_route_q <= '0;
      prev_q      <= 1'b0;
    end else begin
      sh_cmp_q    <= sh_cmp_d;
      sh_slope_q  <= sh_slope_d;
      sh_route_q  <= sh_route_d;
      act_cmp_q   <= act_cmp_d;
      act_slope_q <= act_slope_d;
      act_route_q <= act_route_d;
      prev_q      <= qual;
    end
  end

  assign hit_o     = qual & ~prev_q;
  assign route_o   = act_route_q;
  assign act_cmp_o = act_cmp_q;

endmodule

// File: rtl/adc_trig_route.sv
module adc_trig_route #(
  parameter int N_CMP   = 2,
  parameter int N_OUT   = 4,
  parameter int ROUTE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CMP-1:0]         hit_i,
  input  logic [N_CMP*ROUTE_W-1:0] route_i,
  output logic [N_OUT-1:0]         trig_o
);

  logic [N_OUT-1:0] trig_d, trig_q;

  always_comb begin
    trig_d = '0;
    for (int c = 0; c < N_CMP; c++) begin
      for (int o = 0; o < N_OUT; o++) begin
        if (hit_i[c] && (route_i[c*ROUTE_W +: ROUTE_W] == ROUTE_W'(o)))
          trig_d[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig_d;
  end

  assign trig_o = trig_q;

endmodule

// File: rtl/adc_sync_trig.sv
module adc_sync_trig #(
  parameter int CNT_W = 16,
  parameter int N_CMP = 2,
  parameter int N_OUT = 4,
  localparam int ROUTE_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic                     cnt_up_i,
  input  logic                     pwm_en_i,
  input  logic                     edge_mode_i,
  input  logic                     pwm_sync_i,
  input  logic [N_CMP-1:0]         cmp_we_i,
  input  logic [CNT_W-1:0]         cmp_wdata_i,
  input  logic                     cfg_we_i,
  input  logic [2*N_CMP-1:0]       cfg_slope_i,
  input  logic [N_CMP*ROUTE_W-1:0] cfg_route_i,
  output logic [N_OUT-1:0]         trig_o
);

  logic [N_CMP-1:0]         hit;
  logic [N_CMP*ROUTE_W-1:0] route_all;
  logic [N_CMP*CNT_W-1:0]   act_cmp_all;

  for (genvar c = 0; c < N_CMP; c++) begin : g_chan
    adc_trig_chan #(.CNT_W(CNT_W), .ROUTE_W(ROUTE_W)) u_chan (
      .clk           (clk),
      .rst_n         (rst_n),
      .cnt_i         (cnt_i),
      .cnt_up_i      (cnt_up_i),
      .edge_mode_i   (edge_mode_i),
      .pwm_en_i      (pwm_en_i),
      .sync_i        (pwm_sync_i),
      .cmp_we_i      (cmp_we_i[c]),
      .cmp_wdata_i   (cmp_wdata_i),
      .cfg_we_i      (cfg_we_i),
      .slope_wdata_i (cfg_slope_i[2*c +: 2]),
      .route_wdata_i (cfg_route_i[c*ROUTE_W +: ROUTE_W]),
      .hit_o         (hit[c]),
      .route_o       (route_all[c*ROUTE_W +: ROUTE_W]),
      .act_cmp_o     (act_cmp_all[c*CNT_W +: CNT_W])
    );
  end

  adc_trig_route #(.N_CMP(N_CMP), .N_OUT(N_OUT), .ROUTE_W(ROUTE_W)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .route_i (route_all),
    .trig_o  (trig_o)
  );

endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk #(
  parameter int CNT_W = 16,
  parameter int N_CMP = 2,
  parameter int N_OUT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CNT_W-1:0]       cnt_i,
  input logic                   cnt_up_i,
  input logic                   pwm_en_i,
  input logic                   edge_mode_i,
  input logic                   pwm_sync_i,
  input logic [N_CMP*CNT_W-1:0] act_cmp_i,
  input logic [N_OUT-1:0]       trig_o
);

  logic past_ok;
  logic any_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    any_eq = 1'b0;
    for (int c = 0; c < N_CMP; c++)
      if (cnt_i == act_cmp_i[c*CNT_W +: CNT_W]) any_eq = 1'b1;
  end

  AST_NO_MATCH_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_eq |=> trig_o == '0); // R1

  AST_EDGE_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && !cnt_up_i) |=> trig_o == '0); // R3

  AST_PWM_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en_i |=> trig_o == '0); // R4

  AST_COMMIT_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(pwm_sync_i)) |-> $stable(act_cmp_i)); // R5

  AST_HELD_MATCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $stable(cnt_i) && $stable(cnt_up_i) && $stable(edge_mode_i)
     && $stable(pwm_en_i) && !$past(pwm_sync_i)) |=> trig_o == '0); // R6

endmodule

bind adc_sync_trig adc_trig_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP), .N_OUT(N_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_i       (cnt_i),
  .cnt_up_i    (cnt_up_i),
  .pwm_en_i    (pwm_en_i),
  .edge_mode_i (edge_mode_i),
  .pwm_sync_i  (pwm_sync_i),
  .act_cmp_i   (act_cmp_all),
  .trig_o      (trig_o)
);

// File: tb/adc_sync_trig_bench.sv
`timescale 1ns/1ps
module adc_sync_trig_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_i;
  logic        cnt_up_i, pwm_en_i, edge_mode_i, pwm_sync_i;
  logic [1:0]  cmp_we_i;
  logic [15:0] cmp_wdata_i;
  logic        cfg_we_i;
  logic [3:0]  cfg_slope_i, cfg_route_i;
  logic [3:0]  trig_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_sync_trig u_adc_sync_trig (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_up_i(cnt_up_i),
    .pwm_en_i(pwm_en_i), .edge_mode_i(edge_mode_i), .pwm_sync_i(pwm_sync_i),
    .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i), .cfg_we_i(cfg_we_i),
    .cfg_slope_i(cfg_slope_i), .cfg_route_i(cfg_route_i), .trig_o(trig_o)
  );

  task automatic check(string tag, logic [3:0] exp);
    n_run++;
    if (trig_o !== exp) begin
      n_fail++;
      $display("FAIL %s: trig_o=%b expected %b", tag, trig_o, exp);
    end
  endtask

  task automatic park();
    cnt_i = 16'hFFF0;
    cnt_up_i = 1'b1;
  endtask

  task automatic wr_cmp(int ch, logic [15:0] v);
    @(negedge clk);
    park();
    cmp_we_i = 2'b00;
    cmp_we_i[ch] = 1'b1;
    cmp_wdata_i = v;
    @(negedge clk);
    cmp_we_i = 2'b00;
  endtask

  task automatic wr_cfg(logic [3:0] slope, logic [3:0] route);
    @(negedge clk);
    park();
    cfg_we_i = 1'b1;
    cfg_slope_i = slope;
    cfg_route_i = route;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk);
    park();
    pwm_sync_i = 1'b1;
    @(negedge clk);
    pwm_sync_i = 1'b0;
  endtask

  task automatic step(logic [15:0] c, logic up, logic [3:0] exp, string tag);
    @(negedge clk);
    cnt_i = c;
    cnt_up_i = up;
    @(posedge clk);
    #1;
    check(tag, exp);
  endtask

  task automatic t_reset();
    n_run++;
    if (trig_o !== 4'b0) begin
      n_fail++;
      $display("FAIL R8: trig_o=%b expected 0000 after reset", trig_o);
    end
    step(16'd0, 1'b1, 4'b0000, "R8 count 0 with reset compare");
    step(16'd0, 1'b0, 4'b0000, "R8 count 0 down");
  endtask

  task automatic t_up();
    wr_cmp(0, 16'd100);
    wr_cmp(1, 16'd300);
    wr_cfg(4'b0001, 4'b0100);
    do_sync();
    step(16'd99,  1'b1, 4'b0000, "R1 before match");
    step(16'd100, 1'b1, 4'b0001, "R1 up match");
    step(16'd101, 1'b1, 4'b0000, "R1 after match");
    step(16'd100, 1'b0, 4'b0000, "R2 up-only ignores down");
  endtask

  task automatic t_down();
    wr_cfg(4'b0010, 4'b0010);
    do_sync();
    step(16'd101, 1'b0, 4'b0000, "R2 down approach");
    step(16'd100, 1'b0, 4'b0100, "R2 down match on out2");
    step(16'd99,  1'b0, 4'b0000, "R2 down leave");
    step(16'd100, 1'b1, 4'b0000, "R2 down-only ignores up");
  endtask

  task automatic t_both();
    wr_cfg(4'b0011, 4'b0011);
    do_sync();
    step(16'd100, 1'b1, 4'b1000, "R2 both up");
    step(16'd101, 1'b1, 4'b0000, "R2 both leave");
    step(16'd100, 1'b0, 4'b1000, "R2 both down");
    step(16'd99,  1'b0, 4'b0000, "R2 both leave down");
  endtask

  task automatic t_edge();
    wr_cfg(4'b0010, 4'b0000);
    do_sync();
    edge_mode_i = 1'b1;
    step(16'd100, 1'b0, 4'b0000, "R3 edge mode blocks down");
    step(16'd99,  1'b0, 4'b0000, "R3 leave");
    step(16'd100, 1'b1, 4'b0001, "R3 edge mode forces up");
    step(16'd101, 1'b1, 4'b0000, "R3 leave up");
    edge_mode_i = 1'b0;
  endtask

  task automatic t_pwm_off();
    wr_cfg(4'b0001, 4'b0000);
    do_sync();
    pwm_en_i = 1'b0;
    step(16'd99,  1'b1, 4'b0000, "R4 off approach");
    step(16'd100, 1'b1, 4'b0000, "R4 off at match");
    pwm_en_i = 1'b1;
    step(16'd101, 1'b1, 4'b0000, "R4 re-enabled off match");
  endtask

  task automatic t_shadow();
    wr_cmp(0, 16'd500);
    step(16'd500, 1'b1, 4'b0000, "R5 unsynced compare unused");
    step(16'd100, 1'b1, 4'b0001, "R5 old compare still active");
    step(16'd101, 1'b1, 4'b0000, "R5 leave");
    do_sync();
    step(16'd100, 1'b1, 4'b0000, "R5 old compare retired");
    step(16'd500, 1'b1, 4'b0001, "R5 new compare live");
    step(16'd501, 1'b1, 4'b0000, "R5 leave");
    wr_cfg(4'b0010, 4'b0000);
    step(16'd500, 1'b1, 4'b0001, "R5 unsynced slope unused");
    step(16'd501, 1'b1, 4'b0000, "R5 leave");
    do_sync();
    step(16'd500, 1'b1, 4'b0000, "R5 synced slope down-only");
  endtask

  task automatic t_hold();
    wr_cmp(0, 16'd100);
    wr_cfg(4'b0001, 4'b0000);
    do_sync();
    step(16'd99,  1'b1, 4'b0000, "R6 approach");
    step(16'd100, 1'b1, 4'b0001, "R6 first cycle");
    step(16'd100, 1'b1, 4'b0000, "R6 held second cycle");
    step(16'd100, 1'b1, 4'b0000, "R6 held third cycle");
  endtask

  task automatic t_route();
    wr_cmp(1, 16'd100);
    wr_cfg(4'b0101, 4'b0101);
    do_sync();
    step(16'd99,  1'b1, 4'b0000, "R7 approach");
    step(16'd100, 1'b1, 4'b0010, "R7 shared output OR");
    wr_cfg(4'b0101, 4'b1101);
    do_sync();
    step(16'd99,  1'b1, 4'b0000, "R7 approach");
    step(16'd100, 1'b1, 4'b1010, "R7 split outputs");
    wr_cmp(1, 16'd200);
    do_sync();
    step(16'd100, 1'b1, 4'b0010, "R9 channel 0 alone");
    step(16'd200, 1'b1, 4'b1000, "R9 channel 1 alone");
    step(16'd201, 1'b1, 4'b0000, "R9 leave");
  endtask

  initial begin
    rst_n = 1'b0;
    park();
    pwm_en_i = 1'b1;
    edge_mode_i = 1'b0;
    pwm_sync_i = 1'b0;
    cmp_we_i = 2'b00;
    cmp_wdata_i = '0;
    cfg_we_i = 1'b0;
    cfg_slope_i = '0;
    cfg_route_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_up();
    t_down();
    t_both();
    t_edge();
    t_pwm_off();
    t_shadow();
    t_hold();
    t_route();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule